// File: doc/BRIEF.md
# Scratchpad RAM Window Mapper

This block turns a fixed 64 MB address window into directly addressed on-chip RAM. The RAM is built from the upper half (lines 256 to 511) of the data arrays of two operand-cache ways. A requester issues single-word reads and writes on a simple valid/ready bus. Writes carry per-byte enables. Each accepted request gets exactly one response, one cycle later. That response carries either read data or an error flag.

Two mode inputs decide how the window maps onto storage. In compatible mode, only way 0 backs the RAM, and its 8 KB image repeats every 8 KB. In double-size mode, address bit 13 picks the way, which gives two 8 KB areas that alternate in every 16 KB block. The RAM must not be used together with the cache's alternative index mode. If both are enabled, a configuration error output is raised and every access is refused.

Top module: `spw_scratch_map`

## Requirements
- R1: A request hits the window only when address bits [31:26] equal 6'b011111 (0x7C00_0000 through 0x7FFF_FFFF). Any other address gets an error response and writes nothing.
- R2: With `ext_mode` = 0, every hit maps to way 0. Address bits 13 and [25:14] are ignored, so the 8 KB image repeats every 8 KB up to the top of the window.
- R3: With `ext_mode` = 1, address bit 13 = 0 selects way 0 (area 1) and bit 13 = 1 selects way 1 (area 2). The pair repeats every 16 KB. Way 0 in this mode is the same storage that compatible mode uses.
- R4: The line used is address bits [12:5] (cache entry 256 plus that value). The word in the line is bits [4:2]. Bits [1:0] are ignored.
- R5: `cfg_err` is high exactly when `ram_en` and `index_mode` are both 1. While it is high, every request gets an error response and writes nothing.
- R6: With `ram_en` = 0, every request gets an error response and writes nothing.
- R7: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The cycle after acceptance has `rsp_valid` = 1, and no other cycle does. A successful read returns the stored word then. Write responses and error responses return zero data.
- R8: On a successful write, `req_be[i]` = 1 updates bits [8i+7:8i] of the word, and the other bytes keep their old values.
- R9: While `rst_n` is low, `req_ready`, `rsp_valid`, `rsp_err` and `rsp_rdata` are all 0. `req_ready` rises at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_en | input | 1 | RAM mode enable |
| ext_mode | input | 1 | 0: single 8 KB area; 1: two 8 KB areas |
| index_mode | input | 1 | Cache alternative index mode is active |
| cfg_err | output | 1 | RAM mode and index mode are both enabled |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench builds the block with its default parameters: 32-bit words, 8 words per line, 256 RAM lines per way and two ways. These are the only values for which the window's bit positions line up with the 8 KB and 16 KB repeat periods. With these defaults the last word of line 511, the shadow just below 0x8000_0000, and the way-1 area that exists only in double-size mode can all be reached. The bench also checks that storage written in one mode is seen from the other mode, and that partial byte-enable writes merge with the old data.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int SPW_ADDR_W     = 32;
  localparam int SPW_DATA_W     = 32;
  localparam int SPW_LINE_WORDS = 8;
  localparam int SPW_RAM_LINES  = 256;
  localparam int SPW_WAYS       = 2;
  localparam int SPW_WIN_LO     = 26;
  localparam int SPW_WIN_W      = SPW_ADDR_W - SPW_WIN_LO;
  localparam logic [SPW_WIN_W-1:0] SPW_WIN_TAG = 6'b011111;

  localparam int SPW_BYTE_OFF_W = $clog2(SPW_DATA_W / 8);
  localparam int SPW_WORD_IDX_W = $clog2(SPW_LINE_WORDS);
  localparam int SPW_LINE_IDX_W = $clog2(SPW_RAM_LINES);
  localparam int SPW_WAY_W      = (SPW_WAYS > 1) ? $clog2(SPW_WAYS) : 1;
  localparam int SPW_WAY_BIT    = SPW_BYTE_OFF_W + SPW_WORD_IDX_W + SPW_LINE_IDX_W;

  typedef struct packed {
    logic                      in_win;
    logic [SPW_WAY_W-1:0]      way;
    logic [SPW_LINE_IDX_W-1:0] line;
    logic [SPW_WORD_IDX_W-1:0] word;
  } spw_loc_t;
endpackage

// File: rtl/spw_addr_decode.sv
module spw_addr_decode
  import spw_pkg::*;
(
  input  logic [SPW_ADDR_W-1:0] addr,
  input  logic                  ext_mode,
  output spw_loc_t              loc
);
  logic unused_addr_bits;

  always_comb begin
    loc.in_win = (addr[SPW_ADDR_W-1:SPW_WIN_LO] == SPW_WIN_TAG);
    loc.line   = addr[SPW_WAY_BIT-1 -: SPW_LINE_IDX_W];
    loc.word   = addr[SPW_BYTE_OFF_W +: SPW_WORD_IDX_W];
    if (ext_mode) loc.way = SPW_WAY_W'(addr[SPW_WAY_BIT]);
    else          loc.way = '0;
  end

  assign unused_addr_bits = ^{addr[SPW_WIN_LO-1:SPW_WAY_BIT+1], addr[SPW_BYTE_OFF_W-1:0]};
endmodule

// File: rtl/spw_way_array.sv
module spw_way_array #(
  parameter int DATA_W = 32,
  parameter int WAYS   = 2,
  parameter int LINES  = 256,
  parameter int WORDS  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [WAY_W-1:0]         way,
  input  logic [LINE_W-1:0]        line,
  input  logic [WORD_W-1:0]        word,
  input  logic [NB-1:0]            be,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  localparam int NB     = DATA_W / 8;
  localparam int DEPTH  = LINES * WORDS;
  localparam int LINE_W = $clog2(LINES);
  localparam int WORD_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] way_rd [WAYS];
  logic [DATA_W-1:0] rd_d;

  assign idx = {line, word};

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [DATA_W-1:0] mem [DEPTH];
    logic              sel_wr;

    assign sel_wr    = wr_en && (way == WAY_W'(g));
    assign way_rd[g] = mem[idx];

    always_ff @(posedge clk) begin
      if (sel_wr) begin
        for (int b = 0; b < NB; b++) begin
          if (be[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
        end
      end
    end
  end

  assign rd_d = way_rd[way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_d;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(rdata)) else $error("read register moved without a read"); // R7
  AST_NO_RW_MIX: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && rd_en)) else $error("read and write in one cycle"); // R7
endmodule

// File: rtl/spw_scratch_map.sv
module spw_scratch_map
  import spw_pkg::*;
#(
  parameter int DATA_W = SPW_DATA_W,
  parameter int ADDR_W = SPW_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_en,
  input  logic              ext_mode,
  input  logic              index_mode,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NB-1:0]     req_be,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int NB = DATA_W / 8;

  spw_loc_t          loc;
  logic              accept, ok, wr_en, rd_en;
  logic              ready_q, ready_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;
  logic              rdok_q, rdok_d;
  logic [DATA_W-1:0] arr_rdata;

  spw_addr_decode u_dec (
    .addr     (req_addr),
    .ext_mode (ext_mode),
    .loc      (loc)
  );

  assign cfg_err = ram_en && index_mode;
  assign accept  = req_valid && ready_q;
  assign ok      = loc.in_win && ram_en && !index_mode;
  assign wr_en   = accept && ok && req_write;
  assign rd_en   = accept && ok && !req_write;

  spw_way_array #(
    .DATA_W (DATA_W),
    .WAYS   (SPW_WAYS),
    .LINES  (SPW_RAM_LINES),
    .WORDS  (SPW_LINE_WORDS)
  ) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .way   (loc.way),
    .line  (loc.line),
    .word  (loc.word),
    .be    (req_be),
    .wdata (req_wdata),
    .rdata (arr_rdata)
  );

  always_comb begin
    ready_d = 1'b1;
    vld_d   = accept;
    err_d   = accept && !ok;
    rdok_d  = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      rdok_q  <= 1'b0;
    end else begin
      ready_q <= ready_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
      rdok_q  <= rdok_d;
    end
  end

  assign req_ready = ready_q;
  assign rsp_valid = vld_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdok_q ? arr_rdata : '0;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept |=> rsp_valid) else $error("missing response"); // R7
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n) !accept |=> !rsp_valid) else $error("response without request"); // R7
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> (rsp_rdata == '0)) else $error("data on error"); // R7
  AST_OUTSIDE_ERR: assert property (@(posedge clk) disable iff (!rst_n) (accept && req_addr[ADDR_W-1:SPW_WIN_LO] != SPW_WIN_TAG) |=> rsp_err) else $error("outside address accepted"); // R1
  AST_COMPAT_WAY0: assert property (@(posedge clk) disable iff (!rst_n) (accept && !ext_mode) |-> (loc.way == '0)) else $error("way 1 used in compatible mode"); // R2
  AST_CFG_CONFLICT_ERR: assert property (@(posedge clk) disable iff (!rst_n) (accept && cfg_err) |=> rsp_err) else $error("access during index mode"); // R5
  AST_RAM_OFF_ERR: assert property (@(posedge clk) disable iff (!rst_n) (accept && !ram_en) |=> rsp_err) else $error("access with RAM off"); // R6
  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n) ready_q |=> ready_q) else $error("ready dropped"); // R9
endmodule

// File: tb/spw_scratch_map_bench.sv
module spw_scratch_map_bench;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        en;
    logic        ext;
    logic        idx;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic        err;
    logic [31:0] rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 32'h7C00_0000, 32'h1111_1111, 4'hF, 1'b0, 32'h0,          4'd7}, // R7 write
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h7C00_0000, 32'h0,         4'h0, 1'b0, 32'h1111_1111, 4'd7}, // R7 read back
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h7C00_2000, 32'h0,         4'h0, 1'b0, 32'h1111_1111, 4'd2}, // R2 8 KB shadow
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h7FFF_E000, 32'h0,         4'h0, 1'b0, 32'h1111_1111, 4'd2}, // R2 top shadow
    '{1'b1, 1'b1, 1'b0, 1'b1, 32'h7C00_2000, 32'h2222_2222, 4'hF, 1'b0, 32'h0,          4'd3}, // R3 area 2 write
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'h7C00_0000, 32'h0,         4'h0, 1'b0, 32'h1111_1111, 4'd3}, // R3 area 1 = compat storage
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'h7C00_6000, 32'h0,         4'h0, 1'b0, 32'h2222_2222, 4'd3}, // R3 16 KB repeat, area 2
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'h7C00_4000, 32'h0,         4'h0, 1'b0, 32'h1111_1111, 4'd3}, // R3 16 KB repeat, area 1
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h7C00_2000, 32'h0,         4'h0, 1'b0, 32'h1111_1111, 4'd2}, // R2 bit 13 ignored
    '{1'b1, 1'b0, 1'b0, 1'b1, 32'h7C00_1FFC, 32'hA5A5_A5A5, 4'hF, 1'b0, 32'h0,          4'd4}, // R4 line 511 word 7
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h7C00_1FFF, 32'h0,         4'h0, 1'b0, 32'hA5A5_A5A5, 4'd4}, // R4 low bits ignored
    '{1'b1, 1'b0, 1'b0, 1'b1, 32'h7C00_0024, 32'hCAFE_F00D, 4'hF, 1'b0, 32'h0,          4'd8}, // R8 full word
    '{1'b1, 1'b0, 1'b0, 1'b1, 32'h7C00_0024, 32'h0011_2233, 4'h5, 1'b0, 32'h0,          4'd8}, // R8 bytes 0 and 2
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h7C00_0024, 32'h0,         4'h0, 1'b0, 32'hCA11_F033, 4'd8}, // R8 merged
    '{1'b1, 1'b0, 1'b0, 1'b1, 32'h7BFF_FFFC, 32'hDEAD_BEEF, 4'hF, 1'b1, 32'h0,          4'd1}, // R1 below window
    '{1'b1, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 32'hDEAD_BEEF, 4'hF, 1'b1, 32'h0,          4'd1}, // R1 above window
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h7C00_0000, 32'h9999_9999, 4'hF, 1'b1, 32'h0,          4'd6}, // R6 RAM off write
    '{1'b1, 1'b0, 1'b1, 1'b1, 32'h7C00_0000, 32'h9999_9999, 4'hF, 1'b1, 32'h0,          4'd5}, // R5 conflict write
    '{1'b0, 1'b0, 1'b0, 1'b0, 32'h7C00_0000, 32'h0,         4'h0, 1'b1, 32'h0,          4'd6}, // R6 RAM off read
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h7C00_0000, 32'h0,         4'h0, 1'b0, 32'h1111_1111, 4'd1}  // R1 R5 R6 nothing written
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ram_en, ext_mode, index_mode, cfg_err;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  spw_scratch_map u_spw_scratch_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .ram_en     (ram_en),
    .ext_mode   (ext_mode),
    .index_mode (index_mode),
    .cfg_err    (cfg_err),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic ext, input logic idx, input logic wr,
                       input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    ram_en = en; ext_mode = ext; index_mode = idx;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ram_en = 1'b0; ext_mode = 1'b0; index_mode = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 ready in reset", {31'b0, req_ready}, 32'd0);
    check("R9 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    check("R9 rsp_err in reset", {31'b0, rsp_err}, 32'd0);
    check("R9 rdata in reset", rsp_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready after release", {31'b0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].en, VECS[i].ext, VECS[i].idx, VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].be);
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R%0d vec%0d valid", VECS[i].req, i), {31'b0, rsp_valid}, 32'd1);
      check($sformatf("R%0d vec%0d err", VECS[i].req, i), {31'b0, rsp_err}, {31'b0, VECS[i].err});
      check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rsp_rdata, VECS[i].rd);
    end

    // R7 no response in an idle cycle
    @(negedge clk);
    check("R7 idle no response", {31'b0, rsp_valid}, 32'd0);

    // R5 configuration error output
    ram_en = 1'b1; index_mode = 1'b1; #1;
    check("R5 cfg_err both on", {31'b0, cfg_err}, 32'd1);
    ram_en = 1'b0; #1;
    check("R5 cfg_err index only", {31'b0, cfg_err}, 32'd0);
    ram_en = 1'b1; index_mode = 1'b0; #1;
    check("R5 cfg_err ram only", {31'b0, cfg_err}, 32'd0);

    // R7 back-to-back reads, one response per cycle
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h7C00_2000, 32'h0, 4'h0);
    @(negedge clk);
    check("R7 b2b first", rsp_rdata, 32'h2222_2222);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h7C00_1FFC, 32'h0, 4'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 b2b second", rsp_rdata, 32'hA5A5_A5A5);
    check("R7 b2b second valid", {31'b0, rsp_valid}, 32'd1);
    @(negedge clk);
    check("R7 b2b end", {31'b0, rsp_valid}, 32'd0);

    // R3 way 1 line 511 word 7 is separate from way 0
    drive(1'b1, 1'b1, 1'b0, 1'b1, 32'h7FFF_FFFC, 32'h5A5A_0001, 4'hF);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFC, 32'h0, 4'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 way0 untouched by way1 write", rsp_rdata, 32'hA5A5_A5A5);

    // R9 reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R9 ready in second reset", {31'b0, req_ready}, 32'd0);
    check("R9 rsp_valid in second reset", {31'b0, rsp_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule